// File: doc/BRIEF.md
# DMA Byte Transfer Engine for Audio Samples

This block sits between an 8-bit host data bus and the sample datapath of an audio converter. It moves sample bytes in both directions under a request/acknowledge handshake. A playback frame is fetched from the host when the datapath asks for one, and a capture frame is handed to the host when the datapath offers one. Each request covers one whole sample frame. The request line stays high until every byte of that frame has moved.

The number of bytes in a frame depends on the selected sample format and on whether the channel is mono or stereo. Incoming bytes are packed into a left/right pair of 16-bit samples. Outgoing samples are cut into bytes in the same order. Playback and capture each own a request/acknowledge pair. A shared mode folds both directions onto the first pair, and in that mode playback is served first when both directions want service.

Top module: `dma_frame_mover`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `req_a`, `req_b`, `pb_frame_stb` and `cap_frame_stb` are 0, and `pb_left` and `pb_right` are 0.
- R2: A direction raises its request only while its enable is 1 and its programmed-I/O select is 0. A frame that is asked for while this is not the case waits, and its request rises once the condition holds.
- R3: Once a request is high, it stays high until the accepted strobe of the final byte of the frame. It is 0 in the cycle after that strobe.
- R4: Frame length follows `cfg_fmt` and `cfg_stereo`. `cfg_fmt[2:1]` is the format field and `cfg_fmt[0]` is the companded select: 000 is 8-bit unsigned, 001 is mu-law, 010 is 16-bit little-endian, 011 is A-law, 101 is ADPCM, 110 is 16-bit big-endian, and 100/111 behave as 000. The 8-bit formats take 1 byte in mono and 2 in stereo. The 16-bit formats take 2 in mono and 4 in stereo.
- R5: 16-bit frames carry the left sample first, then the right sample. Little-endian sends each sample low byte first, and big-endian sends it high byte first. In mono, `pb_right` equals `pb_left`.
- R6: In 8-bit unsigned format a byte maps to `{byte ^ 8'h80, 8'h00}`, so 0x00 gives 0x8000, 0x80 gives 0x0000 and 0xFF gives 0x7F00. Capture applies the inverse to the upper byte.
- R7: Companded formats carry the byte unchanged in the low byte of the sample, with the upper byte 0. The left byte comes first.
- R8: ADPCM always moves 4 bytes, whatever `cfg_stereo` is. Left is `{b1,b0}` and right is `{b3,b2}`.
- R9: A playback byte is accepted only on a rising edge of `host_wr` seen while the direction's acknowledge is 1. A strobe while the acknowledge is 0 neither stores data nor advances the frame.
- R10: During a capture frame, `host_rdata` shows the current byte. The frame advances on a falling edge of `host_rd` seen while the acknowledge is 1.
- R11: With `one_chan` at 1, both directions use `req_a`/`ack_a` and `req_b` stays 0. When both are pending together, the playback frame completes before the capture request is raised.
- R12: `pb_frame_stb` and `cap_frame_stb` pulse for exactly one cycle, in the cycle in which the matching request has just dropped after the final byte.
- R13: With `one_chan` at 0, capture uses `req_b`/`ack_b`, and `req_a` is unaffected by capture frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 3 | Format field and companded select |
| cfg_stereo | input | 1 | 1 = stereo frames |
| play_en | input | 1 | Playback enable |
| play_pio | input | 1 | Playback uses programmed I/O (blocks requests) |
| cap_en | input | 1 | Capture enable |
| cap_pio | input | 1 | Capture uses programmed I/O (blocks requests) |
| one_chan | input | 1 | Both directions share request/acknowledge pair A |
| req_a | output | 1 | Request line A |
| ack_a | input | 1 | Acknowledge A |
| req_b | output | 1 | Request line B |
| ack_b | input | 1 | Acknowledge B |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Capture byte to host |
| pb_need | input | 1 | Datapath pulse asking for a playback frame |
| pb_frame_stb | output | 1 | Playback frame assembled |
| pb_left | output | 16 | Playback left sample |
| pb_right | output | 16 | Playback right sample |
| cap_load | input | 1 | Datapath pulse offering a capture frame |
| cap_left_in | input | 16 | Capture left sample |
| cap_right_in | input | 16 | Capture right sample |
| cap_frame_stb | output | 1 | Capture frame fully read by host |

## Verification
On every cycle, the assertions check four things. A request rises only when its direction is enabled and not in programmed-I/O mode. A raised request never drops without an acknowledged final-style strobe. Each frame strobe coincides with the fall of its request. The shared mode never grants both directions at once. Byte ordering, unsigned conversion, companded pass-through, per-format frame lengths and the priority ordering depend on data values and counts. Only the directed scenarios show these, by comparing the assembled samples and the captured bytes with values worked out by hand.

// File: rtl/dmv_pkg.sv
package dmv_pkg;
    localparam int BYTE_W    = 8;
    localparam int SAMP_W    = 2 * BYTE_W;
    localparam int FRAME_MAX = 4;
    localparam int IDX_W     = $clog2(FRAME_MAX);
    localparam int LEN_W     = IDX_W + 1;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [SAMP_W-1:0] samp_t;
    typedef logic [FRAME_MAX-1:0][BYTE_W-1:0] frame_t;
    typedef logic [LEN_W-1:0] len_t;
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        samp_t left;
        samp_t right;
    } pair_t;

    typedef enum logic [2:0] {
        FMT_U8    = 3'b000,
        FMT_MULAW = 3'b001,
        FMT_LE16  = 3'b010,
        FMT_ALAW  = 3'b011,
        FMT_RSV4  = 3'b100,
        FMT_ADPCM = 3'b101,
        FMT_BE16  = 3'b110,
        FMT_RSV7  = 3'b111
    } fmt_e;

    localparam byte_t SIGN_FLIP = byte_t'(1) << (BYTE_W - 1);
    localparam byte_t ZERO_B    = byte_t'(0);

    function automatic len_t frame_len(fmt_e f, logic st);
        len_t n;
        case (f)
            FMT_LE16, FMT_BE16: n = st ? len_t'(4) : len_t'(2);
            FMT_ADPCM:          n = len_t'(4);
            default:            n = st ? len_t'(2) : len_t'(1);
        endcase
        return n;
    endfunction

    function automatic byte_t byte_at(fmt_e f, idx_t i, pair_t p);
        byte_t b;
        case (f)
            FMT_MULAW, FMT_ALAW:
                b = i[0] ? p.right[BYTE_W-1:0] : p.left[BYTE_W-1:0];
            FMT_LE16, FMT_ADPCM:
                case (i)
                    2'd0:    b = p.left[BYTE_W-1:0];
                    2'd1:    b = p.left[SAMP_W-1:BYTE_W];
                    2'd2:    b = p.right[BYTE_W-1:0];
                    default: b = p.right[SAMP_W-1:BYTE_W];
                endcase
            FMT_BE16:
                case (i)
                    2'd0:    b = p.left[SAMP_W-1:BYTE_W];
                    2'd1:    b = p.left[BYTE_W-1:0];
                    2'd2:    b = p.right[SAMP_W-1:BYTE_W];
                    default: b = p.right[BYTE_W-1:0];
                endcase
            default:
                b = (i[0] ? p.right[SAMP_W-1:BYTE_W] : p.left[SAMP_W-1:BYTE_W]) ^ SIGN_FLIP;
        endcase
        return b;
    endfunction

    function automatic pair_t frame_pack(fmt_e f, logic st, frame_t b);
        pair_t p;
        case (f)
            FMT_MULAW, FMT_ALAW: begin
                p.left  = {ZERO_B, b[0]};
                p.right = {ZERO_B, b[1]};
            end
            FMT_LE16, FMT_ADPCM: begin
                p.left  = {b[1], b[0]};
                p.right = {b[3], b[2]};
            end
            FMT_BE16: begin
                p.left  = {b[0], b[1]};
                p.right = {b[2], b[3]};
            end
            default: begin
                p.left  = {b[0] ^ SIGN_FLIP, ZERO_B};
                p.right = {b[1] ^ SIGN_FLIP, ZERO_B};
            end
        endcase
        if (!st && f != FMT_ADPCM) begin
            p.right = p.left;
        end
        return p;
    endfunction
endpackage

// File: rtl/dmv_edge.sv
module dmv_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic hit
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b0;
        else     lvl_q <= lvl;
    end

    generate
        if (RISING) begin : g_rise
            assign hit = lvl & ~lvl_q;
        end else begin : g_fall
            assign hit = ~lvl & lvl_q;
        end
    endgenerate
endmodule

// File: rtl/dmv_req_ctrl.sv
module dmv_req_ctrl
    import dmv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic allow,
    input  logic xfer,
    input  len_t len,
    output logic pend,
    output logic req,
    output logic start,
    output logic last,
    output idx_t idx,
    output logic done
);
    idx_t cnt_q;

    assign start = pend & allow & ~req;
    assign last  = req & xfer & ((len_t'(cnt_q) + len_t'(1)) == len);
    assign idx   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend  <= 1'b0;
            req   <= 1'b0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            if (arm)        pend <= 1'b1;
            else if (start) pend <= 1'b0;

            if (start)     req <= 1'b1;
            else if (last) req <= 1'b0;

            if (start)             cnt_q <= '0;
            else if (req && xfer)  cnt_q <= last ? idx_t'(0) : cnt_q + idx_t'(1);

            done <= last;
        end
    end
endmodule

// File: rtl/dmv_play_asm.sv
module dmv_play_asm
    import dmv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fmt_e  fmt,
    input  logic  stereo,
    input  logic  xfer,
    input  logic  last,
    input  idx_t  idx,
    input  byte_t wdata,
    output samp_t left,
    output samp_t right
);
    frame_t hold_q;
    frame_t merged;
    pair_t  packed_w;

    always_comb begin
        merged      = hold_q;
        merged[idx] = wdata;
    end

    assign packed_w = frame_pack(fmt, stereo, merged);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            left   <= '0;
            right  <= '0;
        end else begin
            if (xfer) hold_q <= merged;
            if (last) begin
                left  <= packed_w.left;
                right <= packed_w.right;
            end
        end
    end
endmodule

// File: rtl/dmv_cap_slice.sv
module dmv_cap_slice
    import dmv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  fmt_e  fmt,
    input  logic  load,
    input  samp_t left_in,
    input  samp_t right_in,
    input  logic  start,
    input  idx_t  idx,
    output byte_t rdata
);
    pair_t stage_q;
    pair_t frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            frame_q <= '0;
        end else begin
            if (load)  stage_q <= '{left: left_in, right: right_in};
            if (start) frame_q <= stage_q;
        end
    end

    assign rdata = byte_at(fmt, idx, frame_q);
endmodule

// File: rtl/dma_frame_mover.sv
module dma_frame_mover
    import dmv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  cfg_fmt,
    input  logic        cfg_stereo,
    input  logic        play_en,
    input  logic        play_pio,
    input  logic        cap_en,
    input  logic        cap_pio,
    input  logic        one_chan,
    output logic        req_a,
    input  logic        ack_a,
    output logic        req_b,
    input  logic        ack_b,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic        pb_need,
    output logic        pb_frame_stb,
    output logic [15:0] pb_left,
    output logic [15:0] pb_right,
    input  logic        cap_load,
    input  logic [15:0] cap_left_in,
    input  logic [15:0] cap_right_in,
    output logic        cap_frame_stb
);
    fmt_e fmt;
    len_t len;
    logic wr_rise, rd_fall;
    logic pb_ok, cap_ok, pb_allow, cap_allow;
    logic pb_pend_i, pb_req_i, pb_start, pb_last, pb_xfer;
    logic cap_pend_i, cap_req_i, cap_start, cap_last, cap_xfer, cap_ack;
    idx_t pb_idx, cap_idx;

    assign fmt = fmt_e'(cfg_fmt);
    assign len = frame_len(fmt, cfg_stereo);

    dmv_edge #(.RISING(1'b1)) u_wr_edge (.clk(clk), .rst(rst), .lvl(host_wr), .hit(wr_rise));
    dmv_edge #(.RISING(1'b0)) u_rd_edge (.clk(clk), .rst(rst), .lvl(host_rd), .hit(rd_fall));

    // direction qualification and shared-channel arbitration (playback wins)
    assign pb_ok     = play_en & ~play_pio;
    assign cap_ok    = cap_en & ~cap_pio;
    assign pb_allow  = pb_ok & ~(one_chan & cap_req_i);
    assign cap_allow = cap_ok & ~(one_chan & (pb_req_i | (pb_pend_i & pb_ok)));

    assign cap_ack  = one_chan ? ack_a : ack_b;
    assign pb_xfer  = pb_req_i & ack_a & wr_rise;
    assign cap_xfer = cap_req_i & cap_ack & rd_fall;

    dmv_req_ctrl u_pb_rc (
        .clk(clk), .rst(rst), .arm(pb_need), .allow(pb_allow), .xfer(pb_xfer),
        .len(len), .pend(pb_pend_i), .req(pb_req_i), .start(pb_start),
        .last(pb_last), .idx(pb_idx), .done(pb_frame_stb)
    );

    dmv_req_ctrl u_cap_rc (
        .clk(clk), .rst(rst), .arm(cap_load), .allow(cap_allow), .xfer(cap_xfer),
        .len(len), .pend(cap_pend_i), .req(cap_req_i), .start(cap_start),
        .last(cap_last), .idx(cap_idx), .done(cap_frame_stb)
    );

    dmv_play_asm u_play (
        .clk(clk), .rst(rst), .fmt(fmt), .stereo(cfg_stereo), .xfer(pb_xfer),
        .last(pb_last), .idx(pb_idx), .wdata(host_wdata),
        .left(pb_left), .right(pb_right)
    );

    dmv_cap_slice u_cap (
        .clk(clk), .rst(rst), .fmt(fmt), .load(cap_load),
        .left_in(cap_left_in), .right_in(cap_right_in),
        .start(cap_start), .idx(cap_idx), .rdata(host_rdata)
    );

    assign req_a = pb_req_i | (one_chan & cap_req_i);
    assign req_b = ~one_chan & cap_req_i;
endmodule

// File: rtl/dmv_checker.sv
module dmv_checker (
    input logic clk,
    input logic rst,
    input logic one_chan,
    input logic play_en,
    input logic play_pio,
    input logic cap_en,
    input logic cap_pio,
    input logic ack_a,
    input logic ack_b,
    input logic host_wr,
    input logic host_rd,
    input logic pb_frame_stb,
    input logic cap_frame_stb,
    input logic pb_req_i,
    input logic cap_req_i,
    input logic cap_pend_i
);
    // R2: request rises only for an enabled, non-PIO direction
    p_pb_gate_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(pb_req_i) |-> $past(play_en && !play_pio));
    p_cap_gate_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(cap_req_i) |-> $past(cap_en && !cap_pio));

    // R3: a raised request holds unless an acknowledged byte strobe arrives
    p_pb_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (pb_req_i && !(ack_a && host_wr && !$past(host_wr))) |=> pb_req_i);
    p_cap_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (cap_req_i && !((one_chan ? ack_a : ack_b) && !host_rd && $past(host_rd))) |=> cap_req_i);

    // R12: frame strobes coincide with the request falling
    p_pb_stb_r12: assert property (@(posedge clk) disable iff (rst)
        pb_frame_stb |-> (!pb_req_i && $past(pb_req_i)));
    p_cap_stb_r12: assert property (@(posedge clk) disable iff (rst)
        cap_frame_stb |-> (!cap_req_i && $past(cap_req_i)));

    // R11: shared mode never serves both directions together
    p_one_owner_r11: assert property (@(posedge clk) disable iff (rst)
        one_chan |-> !(pb_req_i && cap_req_i));

    // R2: a pending capture in a blocked direction does not start
    p_cap_wait_r2: assert property (@(posedge clk) disable iff (rst)
        (cap_pend_i && !cap_req_i && !(cap_en && !cap_pio)) |=> !cap_req_i);
endmodule

bind dma_frame_mover dmv_checker u_chk (
    .clk(clk), .rst(rst), .one_chan(one_chan), .play_en(play_en), .play_pio(play_pio),
    .cap_en(cap_en), .cap_pio(cap_pio), .ack_a(ack_a), .ack_b(ack_b),
    .host_wr(host_wr), .host_rd(host_rd), .pb_frame_stb(pb_frame_stb),
    .cap_frame_stb(cap_frame_stb), .pb_req_i(pb_req_i), .cap_req_i(cap_req_i),
    .cap_pend_i(cap_pend_i)
);

// File: tb/dma_frame_mover_test.sv
module dma_frame_mover_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cfg_fmt = 3'b000;
    logic        cfg_stereo = 1'b0;
    logic        play_en = 1'b1, play_pio = 1'b0, cap_en = 1'b0, cap_pio = 1'b0;
    logic        one_chan = 1'b0;
    logic        req_a, req_b;
    logic        ack_a = 1'b0, ack_b = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic        pb_need = 1'b0, pb_frame_stb;
    logic [15:0] pb_left, pb_right;
    logic        cap_load = 1'b0;
    logic [15:0] cap_left_in = 16'h0, cap_right_in = 16'h0;
    logic        cap_frame_stb;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dma_frame_mover uut (
        .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_stereo(cfg_stereo),
        .play_en(play_en), .play_pio(play_pio), .cap_en(cap_en), .cap_pio(cap_pio),
        .one_chan(one_chan), .req_a(req_a), .ack_a(ack_a), .req_b(req_b), .ack_b(ack_b),
        .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pb_need(pb_need), .pb_frame_stb(pb_frame_stb), .pb_left(pb_left), .pb_right(pb_right),
        .cap_load(cap_load), .cap_left_in(cap_left_in), .cap_right_in(cap_right_in),
        .cap_frame_stb(cap_frame_stb)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic cap_line();
        return one_chan ? req_a : req_b;
    endfunction

    task automatic wait_pb_req();
        int k = 0;
        while (!req_a && k < 12) begin @(negedge clk); k++; end
    endtask

    task automatic wait_cap_req();
        int k = 0;
        while (!cap_line() && k < 12) begin @(negedge clk); k++; end
    endtask

    // writes one byte; returns one negedge after the accepting posedge
    task automatic wr_byte(input logic [7:0] b);
        host_wdata = b;
        host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pb_frame(input logic [2:0] f, input logic st, input logic [31:0] bytes,
                            input int n, input logic [15:0] el, input logic [15:0] er,
                            input string rq);
        @(negedge clk);
        cfg_fmt = f; cfg_stereo = st; pb_need = 1'b1;
        @(negedge clk);
        pb_need = 1'b0;
        wait_pb_req();
        chk({rq, " R2 request raised"}, req_a, 1);
        ack_a = 1'b1;
        for (int i = 0; i < n; i++) begin
            wr_byte(bytes[8*i +: 8]);
            if (i < n - 1) begin
                chk({rq, " R3 request held mid-frame"}, req_a, 1);
                @(negedge clk);
            end else begin
                chk({rq, " R4 request dropped after last byte"}, req_a, 0);
                chk({rq, " R12 frame strobe"}, pb_frame_stb, 1);
                chk({rq, " left"}, pb_left, el);
                chk({rq, " right"}, pb_right, er);
            end
        end
        ack_a = 1'b0;
        @(negedge clk);
        chk({rq, " R12 strobe one cycle"}, pb_frame_stb, 0);
    endtask

    task automatic cap_frame(input logic [2:0] f, input logic st, input logic [15:0] l,
                             input logic [15:0] r, input logic [31:0] bytes, input int n,
                             input string rq);
        @(negedge clk);
        cfg_fmt = f; cfg_stereo = st; cap_en = 1'b1;
        cap_left_in = l; cap_right_in = r; cap_load = 1'b1;
        @(negedge clk);
        cap_load = 1'b0;
        wait_cap_req();
        chk({rq, " R10 capture request raised"}, cap_line(), 1);
        if (!one_chan) chk({rq, " R13 line A idle"}, req_a, 0);
        if (one_chan) ack_a = 1'b1; else ack_b = 1'b1;
        for (int i = 0; i < n; i++) begin
            host_rd = 1'b1;
            #1;
            chk({rq, " R10 read byte"}, host_rdata, bytes[8*i +: 8]);
            @(negedge clk);
            host_rd = 1'b0;
            @(negedge clk);
            if (i < n - 1) begin
                chk({rq, " R3 capture request held"}, cap_line(), 1);
            end else begin
                chk({rq, " R4 capture request dropped"}, cap_line(), 0);
                chk({rq, " R12 capture strobe"}, cap_frame_stb, 1);
            end
        end
        ack_a = 1'b0; ack_b = 1'b0;
        @(negedge clk);
        chk({rq, " R12 capture strobe one cycle"}, cap_frame_stb, 0);
        cap_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 req_a in reset", req_a, 0);
        chk("R1 req_b in reset", req_b, 0);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 play strobe", pb_frame_stb, 0);
        chk("R1 capture strobe", cap_frame_stb, 0);
        chk("R1 samples", {pb_left, pb_right}, 0);
        chk("R1 req_a after reset", req_a, 0);
    endtask

    task automatic t_playback_formats();
        pb_frame(3'b000, 1'b0, 32'h00000000, 1, 16'h8000, 16'h8000, "R6 u8 mono zero");
        pb_frame(3'b000, 1'b0, 32'h000000FF, 1, 16'h7F00, 16'h7F00, "R6 u8 mono full");
        pb_frame(3'b000, 1'b1, 32'h00000180, 2, 16'h0000, 16'h8100, "R6 u8 stereo");
        pb_frame(3'b010, 1'b0, 32'h00001234, 2, 16'h1234, 16'h1234, "R5 le16 mono");
        pb_frame(3'b010, 1'b1, 32'h44332211, 4, 16'h2211, 16'h4433, "R5 le16 stereo");
        pb_frame(3'b110, 1'b1, 32'h44332211, 4, 16'h1122, 16'h3344, "R5 be16 stereo");
        pb_frame(3'b001, 1'b0, 32'h000000A5, 1, 16'h00A5, 16'h00A5, "R7 mulaw mono");
        pb_frame(3'b011, 1'b1, 32'h0000C35A, 2, 16'h005A, 16'h00C3, "R7 alaw stereo");
        pb_frame(3'b101, 1'b0, 32'h04030201, 4, 16'h0201, 16'h0403, "R8 adpcm mono");
    endtask

    task automatic t_ack_ignored();
        @(negedge clk);
        cfg_fmt = 3'b010; cfg_stereo = 1'b0; pb_need = 1'b1;
        @(negedge clk);
        pb_need = 1'b0;
        wait_pb_req();
        ack_a = 1'b0;
        wr_byte(8'hEE);
        chk("R9 strobe without ack keeps request", req_a, 1);
        @(negedge clk);
        ack_a = 1'b1;
        wr_byte(8'h34);
        chk("R9 first acked byte still mid-frame", req_a, 1);
        @(negedge clk);
        wr_byte(8'h12);
        chk("R9 frame ends after two acked bytes", req_a, 0);
        chk("R9 unacked byte not stored", pb_left, 16'h1234);
        ack_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_gating();
        @(negedge clk);
        cfg_fmt = 3'b010; cfg_stereo = 1'b0;
        play_en = 1'b0; play_pio = 1'b0; pb_need = 1'b1;
        @(negedge clk);
        pb_need = 1'b0;
        repeat (5) @(negedge clk);
        chk("R2 disabled direction no request", req_a, 0);
        play_en = 1'b1; play_pio = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 pio direction no request", req_a, 0);
        play_pio = 1'b0;
        wait_pb_req();
        chk("R2 request after gating clears", req_a, 1);
        ack_a = 1'b1;
        wr_byte(8'h00);
        @(negedge clk);
        wr_byte(8'h80);
        chk("R2 gated frame completes", pb_left, 16'h8000);
        ack_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_capture();
        cap_frame(3'b010, 1'b1, 16'hBEEF, 16'h1234, 32'h1234BEEF, 4, "R13 le16 stereo capture");
        cap_frame(3'b000, 1'b0, 16'h8000, 16'h0000, 32'h00000000, 1, "R6 u8 mono capture");
        cap_frame(3'b000, 1'b1, 16'h7F00, 16'h0000, 32'h000080FF, 2, "R6 u8 stereo capture");
        cap_frame(3'b110, 1'b0, 16'hA1B2, 16'h0000, 32'h0000B2A1, 2, "R5 be16 mono capture");
        cap_frame(3'b101, 1'b0, 16'h2211, 16'h4433, 32'h44332211, 4, "R8 adpcm capture");
    endtask

    task automatic t_shared();
        @(negedge clk);
        one_chan = 1'b1; cap_en = 1'b1; play_en = 1'b1;
        cfg_fmt = 3'b010; cfg_stereo = 1'b0;
        cap_left_in = 16'h5566; cap_right_in = 16'h0;
        pb_need = 1'b1; cap_load = 1'b1;
        @(negedge clk);
        pb_need = 1'b0; cap_load = 1'b0;
        wait_pb_req();
        chk("R11 shared request on line A", req_a, 1);
        chk("R11 line B silent", req_b, 0);
        ack_a = 1'b1;
        wr_byte(8'h78);
        @(negedge clk);
        wr_byte(8'h9A);
        chk("R11 playback served first", pb_frame_stb, 1);
        chk("R11 capture not yet done", cap_frame_stb, 0);
        chk("R11 playback sample", pb_left, 16'h9A78);
        @(negedge clk);
        wait_pb_req();
        chk("R11 capture follows on line A", req_a, 1);
        host_rd = 1'b1; #1;
        chk("R11 capture byte 0", host_rdata, 8'h66);
        @(negedge clk); host_rd = 1'b0; @(negedge clk);
        host_rd = 1'b1; #1;
        chk("R11 capture byte 1", host_rdata, 8'h55);
        @(negedge clk); host_rd = 1'b0; @(negedge clk);
        chk("R11 capture strobe", cap_frame_stb, 1);
        chk("R11 line A released", req_a, 0);
        ack_a = 1'b0; one_chan = 1'b0; cap_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_playback_formats();
        t_ack_ignored();
        t_gating();
        t_capture();
        t_shared();
        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule